// File: doc/BRIEF.md
# Programmable Pixel Clock Divider Chain

This block derives a pixel clock from one of two fast clock inputs: a PLL output clock and a reference clock. A parallel-loaded 14-bit configuration word selects the source. It also sets a post-scaler (divide by 1, 2 or 4) and a 4-bit modulus code. The code picks one of twelve encoded moduli between 3 and 20. The pixel clock period is the modulus times the post-scale factor, counted in cycles of the selected source. A test setting of the post-scaler field replaces the divider output with a level taken straight from the configuration word.

The configuration register is written on the reference clock. Its current value is always visible on a readback port. Several bit positions hold fixed values that a write cannot change. An asynchronous reset plays the role of power-up. It puts the register into a state that selects the reference clock, no post-scaling and a modulus of four, and it holds the pixel clock low.

Top module: `pix_clk_gen`

## Requirements
- R1: Configuration word layout: bits [3:0] are the modulus code, bit 6 selects the source, bit 8 is the test level, and bits [13:12] are the post-scale field. Codes 0000..0111 give moduli 3, 4, 4, 5, 6, 8, 8, 10 in code order.
- R2: When code bit 3 is 1, code bit 2 has no effect, and code bits [1:0] equal to 00, 01, 10, 11 give moduli 12, 16, 16, 20.
- R3: Post-scale field 00, 01, 10 divides the source by 1, 2, 4 ahead of the modulus divider. The pixel clock period is modulus × factor source cycles.
- R4: Source bit 6 = 1 clocks the chain from the reference clock, and 0 clocks it from the PLL clock.
- R5: Post-scale field 11 is test mode: one source edge after the setting is seen, the pixel clock follows configuration bit 8.
- R6: For an even modulus the high and low phases are equal. For an odd modulus the high phase is one post-scaled cycle shorter than the low phase.
- R7: While reset is asserted the pixel clock is low and the word reads 0x0061. After reset the output period is 4 reference cycles with a 2-cycle high phase.
- R8: A write stores the data on the next reference edge, except that bits 4, 7, 9, 10 and 11 always read 0 and bit 5 always reads 1, whatever was written.
- R9: A new modulus code or post-scale setting applies only from the next pixel clock rising edge, so the period in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; also clocks the configuration register |
| pllClk | input | 1 | PLL output clock |
| rst | input | 1 | Asynchronous active-high reset (power-up) |
| regWrEn | input | 1 | Configuration write strobe, sampled on refClk |
| regWrData | input | 14 | Configuration write data |
| cfgWord | output | 14 | Current configuration word |
| pixClk | output | 1 | Pixel clock output |

## Verification
The readback word is due one reference edge after the write strobe. The test-mode level is due one source edge after the register changes. A new modulus or post-scale setting applies from the first pixel clock rising edge after the write. The bench therefore waits two rising edges after each configuration change before it times a period. It times rising-to-falling and rising-to-rising intervals in simulation time and compares them with the modulus times the factor times the selected clock period. Test-mode and readback values are sampled several reference cycles after the write, on the falling reference edge.

// File: rtl/pix_clk_pkg.sv
package pix_clk_pkg;
  localparam int CFG_W = 14;
  localparam int CNT_W = 5;
  localparam int PRE_W = 2;

  localparam int CODE_LSB  = 0;
  localparam int SEL_BIT   = 6;
  localparam int AUX_BIT   = 8;
  localparam int POST_LSB  = 12;

  localparam logic [CFG_W-1:0] RST_WORD   = 14'h0061;
  localparam logic [CFG_W-1:0] FIXED_MASK = 14'h0EB0;
  localparam logic [CFG_W-1:0] FIXED_VAL  = 14'h0020;

  typedef struct packed {
    logic [CNT_W-1:0] modulus;
    logic [1:0]       postShift;
    logic             testMode;
    logic             auxLevel;
    logic             selRef;
  } clk_cfg_t;

  function automatic logic [CNT_W-1:0] decodeModulus(input logic [3:0] code);
    logic [CNT_W-1:0] m;
    if (code[3]) begin
      case (code[1:0])
        2'b00:   m = CNT_W'(12);
        2'b11:   m = CNT_W'(20);
        default: m = CNT_W'(16);
      endcase
    end else begin
      case (code[2:0])
        3'd0:    m = CNT_W'(3);
        3'd1,
        3'd2:    m = CNT_W'(4);
        3'd3:    m = CNT_W'(5);
        3'd4:    m = CNT_W'(6);
        3'd5,
        3'd6:    m = CNT_W'(8);
        default: m = CNT_W'(10);
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/pix_clk_ctrl.sv
module pix_clk_ctrl
  import pix_clk_pkg::*;
(
  input  logic             refClk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  output logic [CFG_W-1:0] cfgWord,
  output clk_cfg_t         cfg
);
  logic [CFG_W-1:0] storeReg;
  logic [CFG_W-1:0] storeNext;

  // Writable bits keep the data; fixed positions are forced.
  always_comb storeNext = (regWrData & ~FIXED_MASK) | FIXED_VAL;

  always_ff @(posedge refClk or posedge rst) begin
    if (rst)          storeReg <= RST_WORD;
    else if (regWrEn) storeReg <= storeNext;
  end

  assign cfgWord = storeReg;

  always_comb begin
    cfg.modulus   = decodeModulus(storeReg[CODE_LSB +: 4]);
    cfg.testMode  = (storeReg[POST_LSB +: 2] == 2'b11);
    cfg.postShift = cfg.testMode ? 2'd0 : storeReg[POST_LSB +: 2];
    cfg.auxLevel  = storeReg[AUX_BIT];
    cfg.selRef    = storeReg[SEL_BIT];
  end

  // R8: written data appears one reference edge later
  a_r8_write_code: assert property (@(posedge refClk) disable iff (rst)
    regWrEn |=> (cfgWord[3:0] == $past(regWrData[3:0])) &&
                (cfgWord[13:12] == $past(regWrData[13:12])));

  // R8: fixed positions keep their value across any write
  a_r8_fixed_hold: assert property (@(posedge refClk) disable iff (rst)
    regWrEn |=> ((cfgWord & FIXED_MASK) == $past(cfgWord & FIXED_MASK)));
endmodule

// File: rtl/pix_clk_src_sel.sv
module pix_clk_src_sel (
  input  logic refClk,
  input  logic pllClk,
  input  logic selRef,
  output logic srcClk
);
  assign srcClk = selRef ? refClk : pllClk;
endmodule

// File: rtl/pix_clk_datapath.sv
module pix_clk_datapath
  import pix_clk_pkg::*;
(
  input  logic     srcClk,
  input  logic     rst,
  input  clk_cfg_t cfg,
  output logic     pixClk
);
  localparam logic [CNT_W-1:0] RST_MOD = CNT_W'(4);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMax;
  logic [1:0]       actShift;
  logic [CNT_W-1:0] actMod;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] highLen;
  logic             tick;
  logic             wrap;
  logic             pixReg;

  always_comb begin
    preMax  = PRE_W'((3'd1 << actShift) - 3'd1);
    tick    = (preCnt == preMax);
    wrap    = (divCnt == actMod - CNT_W'(1));
    nextCnt = divCnt + CNT_W'(1);
    highLen = actMod >> 1;
  end

  // post-scaler: one tick every 1, 2 or 4 source cycles
  always_ff @(posedge srcClk or posedge rst) begin
    if (rst)       preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + PRE_W'(1);
  end

  // modulus divider; new settings are latched only at the wrap (rising edge)
  always_ff @(posedge srcClk or posedge rst) begin
    if (rst) begin
      divCnt   <= RST_MOD - CNT_W'(1);
      actMod   <= RST_MOD;
      actShift <= 2'd0;
    end else if (tick) begin
      if (wrap) begin
        divCnt   <= '0;
        actMod   <= cfg.modulus;
        actShift <= cfg.postShift;
      end else begin
        divCnt <= nextCnt;
      end
    end
  end

  always_ff @(posedge srcClk or posedge rst) begin
    if (rst)               pixReg <= 1'b0;
    else if (cfg.testMode) pixReg <= cfg.auxLevel;
    else if (tick)         pixReg <= wrap ? 1'b1 : (nextCnt < highLen);
  end

  assign pixClk = pixReg;

  // R1: divider count stays inside the active modulus
  a_r1_cnt_range: assert property (@(posedge srcClk) disable iff (rst)
    divCnt < actMod);

  // R2: active modulus is always one of the legal values
  a_r2_mod_legal: assert property (@(posedge srcClk) disable iff (rst)
    (actMod >= CNT_W'(3)) && (actMod <= CNT_W'(20)));

  // R3: post-scale counter never passes its terminal count
  a_r3_pre_range: assert property (@(posedge srcClk) disable iff (rst)
    preCnt <= preMax);

  // R5: in test mode the output follows the test level one edge later
  a_r5_aux_follow: assert property (@(posedge srcClk) disable iff (rst)
    cfg.testMode |=> (pixClk == $past(cfg.auxLevel)));

  // R9: outside test mode the output only rises at the start of a period
  a_r9_rise_at_wrap: assert property (@(posedge srcClk) disable iff (rst)
    (!cfg.testMode && !$past(cfg.testMode) && $rose(pixClk)) |-> (divCnt == '0));
endmodule

// File: rtl/pix_clk_gen.sv
module pix_clk_gen
  import pix_clk_pkg::*;
(
  input  logic             refClk,
  input  logic             pllClk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  output logic [CFG_W-1:0] cfgWord,
  output logic             pixClk
);
  clk_cfg_t cfg;
  logic     srcClk;

  pix_clk_ctrl i_ctrl (
    .refClk    (refClk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .cfgWord   (cfgWord),
    .cfg       (cfg)
  );

  pix_clk_src_sel i_src (
    .refClk (refClk),
    .pllClk (pllClk),
    .selRef (cfg.selRef),
    .srcClk (srcClk)
  );

  pix_clk_datapath i_dp (
    .srcClk (srcClk),
    .rst    (rst),
    .cfg    (cfg),
    .pixClk (pixClk)
  );
endmodule

// File: tb/test_pix_clk_gen.sv
`timescale 1ns/1ps
module test_pix_clk_gen;
  localparam int REF_NS = 10;
  localparam int PLL_NS = 4;

  logic        refClk = 1'b0;
  logic        pllClk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [13:0] regWrData = '0;
  logic [13:0] cfgWord;
  logic        pixClk;

  int checks = 0;
  int errors = 0;

  always #(REF_NS/2) refClk = ~refClk;
  always #(PLL_NS/2) pllClk = ~pllClk;

  pix_clk_gen i_pix_clk_gen (
    .refClk(refClk), .pllClk(pllClk), .rst(rst), .regWrEn(regWrEn),
    .regWrData(regWrData), .cfgWord(cfgWord), .pixClk(pixClk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic [3:0] code, input logic sel,
                                     input logic aux, input logic [1:0] s);
    return {s, 3'b000, aux, 1'b0, sel, 2'b10, code};
  endfunction

  function automatic int expMod(input logic [3:0] code);
    int lowTbl [8] = '{3, 4, 4, 5, 6, 8, 8, 10};
    if (code[3]) return (code[1:0] == 2'b00) ? 12 : (code[1:0] == 2'b11) ? 20 : 16;
    return lowTbl[code[2:0]];
  endfunction

  task automatic writeCfg(input logic [13:0] d);
    @(negedge refClk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge refClk);
    regWrEn = 1'b0;
  endtask

  task automatic measure(output int per, output int hi);
    realtime t0, t1, t2;
    @(posedge pixClk); t0 = $realtime;
    @(negedge pixClk); t1 = $realtime;
    @(posedge pixClk); t2 = $realtime;
    per = $rtoi(t2 - t0);
    hi  = $rtoi(t1 - t0);
  endtask

  task automatic settle();
    @(posedge pixClk);
    @(posedge pixClk);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int per, hi, m, f, expHi;
    // R7: reset state
    #23;
    check("R7 pixClk low in reset", int'(pixClk), 0);
    check("R7 reset word", int'(cfgWord), 'h61);
    @(negedge refClk);
    rst = 1'b0;
    settle();
    measure(per, hi);
    check("R7 default period", per, 4 * REF_NS);
    check("R7 default high", hi, 2 * REF_NS);

    // R1 R2 R3 R6: all codes and post-scale settings on the PLL clock
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 16; c++) begin
        writeCfg(mk(4'(c), 1'b0, 1'b0, 2'(s)));
        settle();
        measure(per, hi);
        m = expMod(4'(c));
        f = 1 << s;
        expHi = (m / 2) * f * PLL_NS;
        if (c < 8) check("R1 R3 period", per, m * f * PLL_NS);
        else       check("R2 R3 period", per, m * f * PLL_NS);
        check("R6 high phase", hi, expHi);
        check("R6 low minus high", (per - hi) - hi, (m % 2) * f * PLL_NS);
      end
    end

    // R4: reference source
    for (int c = 0; c < 16; c += 5) begin
      writeCfg(mk(4'(c), 1'b1, 1'b0, 2'b01));
      settle(); settle();
      measure(per, hi);
      check("R4 reference period", per, expMod(4'(c)) * 2 * REF_NS);
    end
    writeCfg(mk(4'b1011, 1'b0, 1'b0, 2'b00));
    settle(); settle();
    measure(per, hi);
    check("R4 back to PLL period", per, 20 * PLL_NS);

    // R9: change mid-period, current period completes unchanged
    @(posedge pixClk);
    begin
      realtime t0, t1;
      t0 = $realtime;
      writeCfg(mk(4'b0000, 1'b0, 1'b0, 2'b00));
      @(negedge pixClk); t1 = $realtime;
      check("R9 old high phase kept", $rtoi(t1 - t0), 10 * PLL_NS);
      @(posedge pixClk); t1 = $realtime;
      check("R9 old period kept", $rtoi(t1 - t0), 20 * PLL_NS);
    end
    measure(per, hi);
    check("R9 new period applied", per, 3 * PLL_NS);

    // R5: test mode
    writeCfg(mk(4'b0001, 1'b1, 1'b1, 2'b11));
    repeat (3) @(negedge refClk);
    check("R5 test level high", int'(pixClk), 1);
    repeat (6) @(negedge refClk);
    check("R5 held high", int'(pixClk), 1);
    writeCfg(mk(4'b0001, 1'b1, 1'b0, 2'b11));
    repeat (3) @(negedge refClk);
    check("R5 test level low", int'(pixClk), 0);

    // R8: fixed bits
    writeCfg(14'h3FFF);
    @(negedge refClk);
    check("R8 all ones readback", int'(cfgWord), 'h316F);
    writeCfg(14'h0000);
    @(negedge refClk);
    check("R8 all zeros readback", int'(cfgWord), 'h0020);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule